// File: doc/BRIEF.md
# Machine Status Word with Supervisor Alias

This block keeps the machine-level status word of a single hart and offers a second, narrower supervisor window onto the same storage. A write strobe, a view select and a data word come in. The block filters each write through a mask of writable fields. It drops a previous-privilege value that names an unimplemented or reserved mode. It collapses the floating-point state field to either off or dirty, and it recomputes the summary dirty bit at the top of the word.

Two static flags tell the block whether supervisor mode and user mode exist. A supervisor-view write is first merged into the current machine word under the supervisor field mask, then sent through the same legalization path as a machine write. A write that changes any field affecting address translation raises a one-cycle flush pulse. Trap entry and return updates are handled elsewhere.

Top module: `mstat_reg`

## Requirements
- R1: While reset is held and after it is released, `mstat_o` reads 0x00001800: the previous-privilege field [12:11] holds machine mode 2'b11 and every other bit is 0. `sstat_o` reads 0 and `flush_o` reads 0.
- R2: A machine-view write (`wr_sview_i`=0) loads only these bits from `wr_data_i`: bit 1 (supervisor interrupt enable), bit 3 (machine interrupt enable), bit 5 (supervisor prior enable), bit 7 (machine prior enable), bit 8 (supervisor prior privilege), [12:11] (machine prior privilege), [14:13] (FP state), bit 17 (modify privilege), bit 18 (supervisor user-memory access) and bit 19 (make executable readable). Bit 0, bit 4, [16:15] (extension state) and all other unnamed bits keep their values. The new word is visible in the cycle after the write edge.
- R3: A write whose proposed [12:11] value is 2'b10, or 2'b01 while `has_smode_i`=0, or 2'b00 while `has_umode_i`=0, leaves [12:11] unchanged. The other fields of the same write still take effect. The value 2'b11 is always accepted.
- R4: After a write, a nonzero FP state value [14:13] is stored as 2'b11, and zero is stored as 2'b00.
- R5: After every write, bit XLEN-1 equals 1 exactly when [14:13] is 2'b11 or [16:15] is 2'b11.
- R6: `flush_o` is 1 in the cycle after a write edge when the proposed word differs from the stored word in bit 19, [12:11], bit 17 or bit 18. The proposed word is the write data for a machine write and the merged word for a supervisor write, so the flush still fires when a discarded [12:11] value differs. Otherwise `flush_o` is 0.
- R7: `sstat_o` equals the stored word masked to bits 0, 1, 4, 5, 8, [14:13], [16:15], 18, 19 and XLEN-1.
- R8: A supervisor-view write (`wr_sview_i`=1) changes no bit outside the supervisor mask. In particular, bits 3, 7, [12:11] and 17 keep their values. Inside the mask it obeys R2, R4 and R5.
- R9: In a cycle with `wr_en_i`=0, the stored word does not change, and `flush_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sview_i | input | 1 | 1 selects the supervisor view for the write |
| wr_data_i | input | XLEN | Write data |
| has_smode_i | input | 1 | Supervisor mode is implemented (static) |
| has_umode_i | input | 1 | User mode is implemented (static) |
| mstat_o | output | XLEN | Machine-view read value |
| sstat_o | output | XLEN | Supervisor-view read value |
| flush_o | output | 1 | One-cycle translation flush pulse |

## Verification
The hardest situation to reach is a write that is partly accepted. Its previous-privilege value is discarded because the matching mode is absent, while its other fields land, and the discarded value alone still triggers a flush. The bench reaches this by resetting the block with each combination of mode flags. After each reset it issues machine writes whose privilege field names the missing mode, along with changes to enable bits. A long pseudo-random run that mixes machine and supervisor writes is then compared cycle by cycle with a field-level reference model.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int unsigned B_UIE  = 0;
  localparam int unsigned B_SIE  = 1;
  localparam int unsigned B_MIE  = 3;
  localparam int unsigned B_UPIE = 4;
  localparam int unsigned B_SPIE = 5;
  localparam int unsigned B_MPIE = 7;
  localparam int unsigned B_SPP  = 8;
  localparam int unsigned B_MPP  = 11;
  localparam int unsigned B_FS   = 13;
  localparam int unsigned B_XS   = 15;
  localparam int unsigned B_MPRV = 17;
  localparam int unsigned B_SUM  = 18;
  localparam int unsigned B_MXR  = 19;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  localparam logic [1:0] FS_OFF   = 2'b00;
  localparam logic [1:0] FS_DIRTY = 2'b11;

  // masks below bit 32; the summary bit is added per XLEN
  localparam logic [63:0] M_WRITE_MASK =
      (64'h1 << B_SIE) | (64'h1 << B_MIE) | (64'h1 << B_SPIE) | (64'h1 << B_MPIE) |
      (64'h1 << B_SPP) | (64'h3 << B_MPP) | (64'h3 << B_FS) | (64'h1 << B_MPRV) |
      (64'h1 << B_SUM) | (64'h1 << B_MXR);

  localparam logic [63:0] S_VIEW_MASK_LO =
      (64'h1 << B_UIE) | (64'h1 << B_SIE) | (64'h1 << B_UPIE) | (64'h1 << B_SPIE) |
      (64'h1 << B_SPP) | (64'h3 << B_FS) | (64'h3 << B_XS) | (64'h1 << B_SUM) |
      (64'h1 << B_MXR);

  localparam logic [63:0] XLATE_MASK =
      (64'h1 << B_MXR) | (64'h3 << B_MPP) | (64'h1 << B_MPRV) | (64'h1 << B_SUM);

  localparam logic [63:0] RESET_WORD = 64'(PRIV_M) << B_MPP;
endpackage

// File: rtl/mstat_view_merge.sv
module mstat_view_merge
  import mstat_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            sview_i,
  output logic [XLEN-1:0] prop_o
);
  localparam logic [XLEN-1:0] SD_BIT = XLEN'(64'h1 << (XLEN - 1));
  localparam logic [XLEN-1:0] SMASK  = XLEN'(S_VIEW_MASK_LO) | SD_BIT;

  // supervisor writes become a full machine word before legalization
  always_comb begin
    if (sview_i) prop_o = (cur_i & ~SMASK) | (wdata_i & SMASK);
    else         prop_o = wdata_i;
  end
endmodule

// File: rtl/mstat_legalize.sv
module mstat_legalize
  import mstat_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] prop_i,
  input  logic            has_smode_i,
  input  logic            has_umode_i,
  output logic [XLEN-1:0] next_o
);
  localparam int unsigned     SD_POS   = XLEN - 1;
  localparam logic [XLEN-1:0] WMASK    = XLEN'(M_WRITE_MASK);
  localparam logic [XLEN-1:0] MPP_MASK = XLEN'(64'h3 << B_MPP);

  logic [1:0]      mpp_req;
  logic            mpp_ok;
  logic [XLEN-1:0] eff_mask;
  logic [XLEN-1:0] merged;

  always_comb begin
    mpp_req = prop_i[B_MPP +: 2];
    case (mpp_req)
      PRIV_M:  mpp_ok = 1'b1;
      PRIV_S:  mpp_ok = has_smode_i;
      PRIV_U:  mpp_ok = has_umode_i;
      default: mpp_ok = 1'b0;
    endcase
    eff_mask = mpp_ok ? WMASK : (WMASK & ~MPP_MASK);
    merged   = (cur_i & ~eff_mask) | (prop_i & eff_mask);
    if (merged[B_FS +: 2] != FS_OFF) merged[B_FS +: 2] = FS_DIRTY;
    merged[SD_POS] = (merged[B_FS +: 2] == FS_DIRTY) || (merged[B_XS +: 2] == 2'b11);
    next_o = merged;
  end
endmodule

// File: rtl/mstat_flush_cmp.sv
module mstat_flush_cmp
  import mstat_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] prop_i,
  output logic            flush_req_o
);
  localparam logic [XLEN-1:0] XMASK = XLEN'(XLATE_MASK);

  // compared on the proposed word, before field legalization
  assign flush_req_o = |((cur_i ^ prop_i) & XMASK);
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
  import mstat_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sview_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            has_smode_i,
  input  logic            has_umode_i,
  output logic [XLEN-1:0] mstat_o,
  output logic [XLEN-1:0] sstat_o,
  output logic            flush_o
);
  localparam logic [XLEN-1:0] SD_BIT   = XLEN'(64'h1 << (XLEN - 1));
  localparam logic [XLEN-1:0] SMASK    = XLEN'(S_VIEW_MASK_LO) | SD_BIT;
  localparam logic [XLEN-1:0] RST_VAL  = XLEN'(RESET_WORD);

  logic [XLEN-1:0] stat_q;
  logic [XLEN-1:0] prop;
  logic [XLEN-1:0] stat_d;
  logic            flush_req;
  logic            flush_q;

  mstat_view_merge #(.XLEN(XLEN)) u_merge (
    .cur_i   (stat_q),
    .wdata_i (wr_data_i),
    .sview_i (wr_sview_i),
    .prop_o  (prop)
  );

  mstat_legalize #(.XLEN(XLEN)) u_legal (
    .cur_i       (stat_q),
    .prop_i      (prop),
    .has_smode_i (has_smode_i),
    .has_umode_i (has_umode_i),
    .next_o      (stat_d)
  );

  mstat_flush_cmp #(.XLEN(XLEN)) u_flush (
    .cur_i       (stat_q),
    .prop_i      (prop),
    .flush_req_o (flush_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= RST_VAL;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en_i & flush_req;
      if (wr_en_i) stat_q <= stat_d;
    end
  end

  assign mstat_o = stat_q;
  assign sstat_o = stat_q & SMASK;
  assign flush_o = flush_q;
endmodule

// File: rtl/mstat_reg_chk.sv
module mstat_reg_chk
  import mstat_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            wr_sview_i,
  input logic            has_smode_i,
  input logic            has_umode_i,
  input logic [XLEN-1:0] mstat_o,
  input logic            flush_o
);
  localparam logic [XLEN-1:0] SD_BIT = XLEN'(64'h1 << (XLEN - 1));
  localparam logic [XLEN-1:0] KEEP   = ~(XLEN'(M_WRITE_MASK) | SD_BIT);
  localparam logic [XLEN-1:0] SLOCK  =
      XLEN'((64'h1 << B_MIE) | (64'h1 << B_MPIE) | (64'h3 << B_MPP) | (64'h1 << B_MPRV));

  AST_KEEP_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mstat_o & KEEP)); // R2

  AST_MPP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstat_o[B_MPP +: 2] != 2'b10) &&
    (has_smode_i || mstat_o[B_MPP +: 2] != 2'b01) &&
    (has_umode_i || mstat_o[B_MPP +: 2] != 2'b00)); // R3

  AST_FS_OFF_OR_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstat_o[B_FS +: 2] == 2'b00) || (mstat_o[B_FS +: 2] == 2'b11)); // R4

  AST_SD_DERIVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstat_o[XLEN-1] == ((mstat_o[B_FS +: 2] == 2'b11) || (mstat_o[B_XS +: 2] == 2'b11))); // R5

  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_en_i)); // R6

  AST_SVIEW_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sview_i) |=> $stable(mstat_o & SLOCK)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mstat_o) && !flush_o)); // R9
endmodule

bind mstat_reg mstat_reg_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sview_i  (wr_sview_i),
  .has_smode_i (has_smode_i),
  .has_umode_i (has_umode_i),
  .mstat_o     (mstat_o),
  .flush_o     (flush_o)
);

// File: tb/mstat_reg_test.sv
`timescale 1ns/1ps
module mstat_reg_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sview = 1'b0;
  logic [31:0] wr_data = '0;
  logic        has_s = 1'b1;
  logic        has_u = 1'b1;
  logic [31:0] mstat, sstat;
  logic        flush;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mstat_reg #(.XLEN(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sview_i(wr_sview),
    .wr_data_i(wr_data), .has_smode_i(has_s), .has_umode_i(has_u),
    .mstat_o(mstat), .sstat_o(sstat), .flush_o(flush)
  );

  // reference model: one variable per field
  bit       m_uie, m_sie, m_mie, m_upie, m_spie, m_mpie, m_spp, m_mprv, m_sum, m_mxr;
  bit [1:0] m_mpp, m_fs, m_xs;
  bit       m_flush;

  function automatic logic [31:0] pack(bit sv);
    logic [31:0] w = '0;
    w[0] = m_uie; w[1] = m_sie; w[4] = m_upie; w[5] = m_spie; w[8] = m_spp;
    w[14:13] = m_fs; w[16:15] = m_xs; w[18] = m_sum; w[19] = m_mxr;
    w[31] = (m_fs == 2'b11) || (m_xs == 2'b11);
    if (!sv) begin
      w[3] = m_mie; w[7] = m_mpie; w[12:11] = m_mpp; w[17] = m_mprv;
    end
    return w;
  endfunction

  task automatic model_reset();
    m_uie = 0; m_sie = 0; m_mie = 0; m_upie = 0; m_spie = 0; m_mpie = 0;
    m_spp = 0; m_mprv = 0; m_sum = 0; m_mxr = 0; m_mpp = 2'b11; m_fs = 0; m_xs = 0;
    m_flush = 0;
  endtask

  task automatic model_write(bit sv, logic [31:0] d);
    bit       fl;
    bit [1:0] req;
    if (sv) begin
      fl = (d[19] != m_mxr) || (d[18] != m_sum);
      m_sie = d[1]; m_spie = d[5]; m_spp = d[8]; m_sum = d[18]; m_mxr = d[19];
      m_fs = (d[14:13] != 0) ? 2'b11 : 2'b00;
    end else begin
      fl = (d[19] != m_mxr) || (d[12:11] != m_mpp) || (d[17] != m_mprv) || (d[18] != m_sum);
      m_sie = d[1]; m_mie = d[3]; m_spie = d[5]; m_mpie = d[7]; m_spp = d[8];
      m_mprv = d[17]; m_sum = d[18]; m_mxr = d[19];
      m_fs = (d[14:13] != 0) ? 2'b11 : 2'b00;
      req = d[12:11];
      if (!((req == 2'b10) || (req == 2'b01 && !has_s) || (req == 2'b00 && !has_u)))
        m_mpp = req;
    end
    m_flush = fl;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "mstat", mstat, pack(1'b0));
    chk("R7", "sstat", sstat, pack(1'b1));
    chk(tag, "flush", {31'b0, flush}, {31'b0, m_flush});
  endtask

  task automatic step(bit we, bit sv, logic [31:0] d, string tag);
    wr_en = we; wr_sview = sv; wr_data = d;
    @(posedge clk);
    if (we) model_write(sv, d); else m_flush = 0;
    @(negedge clk);
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset(bit s, bit u);
    rst_ni = 1'b0; has_s = s; has_u = u; wr_en = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] x;
    @(negedge clk);
    do_reset(1'b1, 1'b1);
    chk("R1", "reset word", mstat, 32'h0000_1800);

    step(1, 0, 32'hFFFF_FFFF, "R2");          // all fields, FS dirty, flush
    chk("R5", "sd set", {31'b0, mstat[31]}, 32'h1);
    step(1, 0, 32'h0000_2000, "R4");          // FS=01 -> 11, MPP->U
    chk("R4", "fs forced", {30'b0, mstat[14:13]}, 32'h3);
    step(1, 0, 32'h0000_0000, "R5");          // FS off, SD clears
    chk("R5", "sd clear", {31'b0, mstat[31]}, 32'h0);
    step(1, 0, 32'h0000_1000, "R3");          // reserved MPP dropped
    chk("R3", "mpp rsvd kept", {30'b0, mstat[12:11]}, 32'h0);
    step(1, 0, 32'h0000_1000, "R6");          // same data again, flush again
    step(1, 0, 32'h0000_0000, "R6");          // no translation change
    step(1, 1, 32'hFFFF_FFFF, "R8");          // supervisor alias write
    chk("R8", "mie kept", {31'b0, mstat[3]}, 32'h0);
    step(0, 0, 32'hFFFF_FFFF, "R9");
    step(0, 1, 32'h0000_0000, "R9");
    step(1, 1, 32'h0000_0000, "R8");

    do_reset(1'b0, 1'b1);
    step(1, 0, 32'h0000_080A, "R3");          // MPP=S absent, SIE/MIE land
    chk("R3", "mpp s dropped", {30'b0, mstat[12:11]}, 32'h3);
    chk("R3", "sie landed", {31'b0, mstat[1]}, 32'h1);
    step(1, 0, 32'h0000_0000, "R3");          // MPP=U legal

    do_reset(1'b1, 1'b0);
    step(1, 0, 32'h0000_0080, "R3");          // MPP=U absent
    chk("R3", "mpp u dropped", {30'b0, mstat[12:11]}, 32'h3);
    step(1, 0, 32'h0000_0800, "R3");          // MPP=S legal

    do_reset(1'b1, 1'b1);
    x = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      bit we, sv;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      we = x[0] | x[1];
      sv = x[2];
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      step(we, sv, x, we ? (sv ? "R8" : "R2") : "R9");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule